// File: doc/BRIEF.md
# Base-Bounds Address Translator

This block turns a 32-bit virtual address into a physical address without a TLB. The low half of the virtual space is the user segment. It is relocated by a base and bound register pair: instruction fetches use one pair, and loads and stores use the other. The upper half holds three fixed kernel segments:

- a cached window and an uncached window, each mapped by clearing the top three address bits;
- a kernel-only window that passes through unchanged.

Each request presents an address, an access type and a user/kernel mode flag. One clock later the block returns the physical address, a cache attribute and an address-error flag. The cache attribute comes from a per-region attribute register that holds eight 3-bit fields, one for each 512 MB region.

Software loads the five configuration registers through a single write port. A write takes effect for requests presented from the next cycle on. A request presented in the same cycle as a write still sees the old value.

The design has no multi-cycle sequence. Each request is classified into one of four named segment states: SEG_USER, SEG_KCACHED, SEG_KUNCACHED and SEG_KONLY. The result register is updated from that state on every clock.

Top module: `bbx_xlate`

## Requirements
- R1: After reset, rsp_valid is 0. Every base, bound and attribute register holds 0, so every user-segment request faults until a bound is written.
- R2: rsp_valid equals req_valid delayed by one clock, and the whole response belongs to the request of the previous cycle.
- R3: A user-segment address (bit 31 clear) with vaddr < bound of the selected pair translates to paddr = (vaddr + base) mod 2^32 with rsp_fault = 0. acc_type 0 (fetch) selects the instruction pair; acc_type 1 (load) and 2 (store) select the data pair.
- R4: A user-segment address with vaddr >= bound of the selected pair gives rsp_fault = 1, rsp_paddr = 0 and rsp_attr = 0.
- R5: In kernel mode, vaddr[31:29] = 3'b100 gives paddr = vaddr with bits 31:29 cleared, no fault, and the attribute of region 4.
- R6: In kernel mode, vaddr[31:29] = 3'b101 gives paddr = vaddr with bits 31:29 cleared, no fault, and rsp_attr = 3'd2 (uncached), whatever region 5 holds.
- R7: In kernel mode, vaddr[31:30] = 2'b11 gives paddr = vaddr, no fault, and the attribute of region vaddr[31:29].
- R8: In user mode (req_user = 1), any address with bit 31 set faults, with paddr 0 and attr 0.
- R9: Region r's attribute is held in bits [3r+2:3r] of the attribute register. A non-faulting user-segment request reports the field of region vaddr[31:29].
- R10: When cfg_we = 1, cfg_sel picks the register written from cfg_wdata. The codes are 0 instruction base, 1 instruction bound, 2 data base, 3 data bound, and 4 attribute (bits 23:0). Codes 5 to 7 change nothing. A written value applies to requests presented from the next cycle.
- R11: acc_type 3 is treated as a data access: it uses the data pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 data |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_attr | output | 3 | Cache attribute |
| rsp_fault | output | 1 | Address-error flag |

## Verification
The hardest cases to reach are the exact bound edge and address wrap-around. A fault must appear at vaddr equal to the bound but not one below it, and relocated sums must wrap past 2^32. Uniform random addresses almost never land on these values. The stimulus therefore draws addresses from a small set built around the current bound values and near zero, in addition to random ones. It also reprograms the registers often, with very large bases, so that edges and wrap-around are hit repeatedly. A write in the same cycle as a request is driven on purpose, to show that the request sees the old value.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_DATA  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        SEL_IBASE = 3'd0,
        SEL_ILIM  = 3'd1,
        SEL_DBASE = 3'd2,
        SEL_DLIM  = 3'd3,
        SEL_ATTR  = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        SEG_USER      = 2'd0,
        SEG_KCACHED   = 2'd1,
        SEG_KUNCACHED = 2'd2,
        SEG_KONLY     = 2'd3
    } seg_e;

    localparam logic [2:0] ATTR_UNCACHED = 3'd2;
endpackage

// File: rtl/bbx_cfg_regs.sv
module bbx_cfg_regs #(
    parameter int AW       = 32,
    parameter int ATTR_W   = 3,
    parameter int RGN_BITS = 3,
    localparam int NRGN    = 1 << RGN_BITS,
    localparam int ATTR_RW = NRGN * ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [AW-1:0]     wdata,
    output logic [AW-1:0]     base   [2],
    output logic [AW-1:0]     limit  [2],
    output logic [ATTR_RW-1:0] attr
);
    import bbx_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base[0]  <= '0;
            base[1]  <= '0;
            limit[0] <= '0;
            limit[1] <= '0;
            attr     <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_IBASE: base[0]  <= wdata;
                SEL_ILIM:  limit[0] <= wdata;
                SEL_DBASE: base[1]  <= wdata;
                SEL_DLIM:  limit[1] <= wdata;
                SEL_ATTR:  attr     <= wdata[ATTR_RW-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/bbx_seg_decode.sv
module bbx_seg_decode
    import bbx_pkg::*;
(
    input  logic [2:0] top_bits,
    output seg_e       seg
);
    always_comb begin
        unique case (top_bits)
            3'b100:  seg = SEG_KCACHED;
            3'b101:  seg = SEG_KUNCACHED;
            3'b110,
            3'b111:  seg = SEG_KONLY;
            default: seg = SEG_USER;
        endcase
    end
endmodule

// File: rtl/bbx_bound_check.sv
module bbx_bound_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          in_bounds,
    output logic [AW-1:0] reloc
);
    always_comb begin
        in_bounds = (vaddr < limit);
        reloc     = vaddr + base;
    end
endmodule

// File: rtl/bbx_xlate.sv
module bbx_xlate #(
    parameter int AW       = 32,
    parameter int ATTR_W   = 3,
    parameter int RGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [1:0]        req_type,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_fault
);
    import bbx_pkg::*;

    localparam int NRGN    = 1 << RGN_BITS;
    localparam int ATTR_RW = NRGN * ATTR_W;
    localparam int NSIDE   = 2;

    logic [AW-1:0]      base  [NSIDE];
    logic [AW-1:0]      limit [NSIDE];
    logic [ATTR_RW-1:0] attr_reg;
    logic [NSIDE-1:0]   inb;
    logic [AW-1:0]      reloc [NSIDE];
    seg_e               seg;
    logic               side;
    logic [RGN_BITS-1:0] rgn;
    logic [ATTR_W-1:0]  rgn_attr;

    logic [AW-1:0]      nx_paddr;
    logic [ATTR_W-1:0]  nx_attr;
    logic               nx_fault;

    bbx_cfg_regs #(.AW(AW), .ATTR_W(ATTR_W), .RGN_BITS(RGN_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .base(base), .limit(limit), .attr(attr_reg)
    );

    bbx_seg_decode u_seg (
        .top_bits(req_vaddr[AW-1 -: 3]),
        .seg(seg)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        bbx_bound_check #(.AW(AW)) u_chk (
            .vaddr(req_vaddr), .base(base[s]), .limit(limit[s]),
            .in_bounds(inb[s]), .reloc(reloc[s])
        );
    end

    always_comb begin
        side     = (acc_e'(req_type) != ACC_FETCH);
        rgn      = req_vaddr[AW-1 -: RGN_BITS];
        rgn_attr = attr_reg[rgn*ATTR_W +: ATTR_W];
        nx_paddr = '0;
        nx_attr  = '0;
        nx_fault = 1'b0;
        unique case (seg)
            SEG_USER: begin
                if (inb[side]) begin
                    nx_paddr = reloc[side];
                    nx_attr  = rgn_attr;
                end else begin
                    nx_fault = 1'b1;
                end
            end
            SEG_KCACHED: begin
                nx_paddr = {3'b000, req_vaddr[AW-4:0]};
                nx_attr  = rgn_attr;
            end
            SEG_KUNCACHED: begin
                nx_paddr = {3'b000, req_vaddr[AW-4:0]};
                nx_attr  = ATTR_UNCACHED;
            end
            SEG_KONLY: begin
                nx_paddr = req_vaddr;
                nx_attr  = rgn_attr;
            end
        endcase
        if (req_user && seg != SEG_USER) begin
            nx_fault = 1'b1;
            nx_paddr = '0;
            nx_attr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_attr  <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= nx_paddr;
            rsp_attr  <= nx_attr;
            rsp_fault <= nx_fault;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    user_kseg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_vaddr[AW-1]) |=> (rsp_fault && rsp_paddr == '0));
    // R6
    kuncached_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && req_vaddr[AW-1 -: 3] == 3'b101)
        |=> (!rsp_fault && rsp_attr == ATTR_UNCACHED));
    // R5
    kcached_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && req_vaddr[AW-1 -: 3] == 3'b100)
        |=> (!rsp_fault && rsp_paddr == {3'b000, $past(req_vaddr[AW-4:0])}));
    // R7
    konly_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && req_vaddr[AW-1 -: 2] == 2'b11)
        |=> (!rsp_fault && rsp_paddr == $past(req_vaddr)));
    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_attr == '0));
endmodule

// File: tb/bbx_xlate_test.sv
module bbx_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_type = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_attr;
    logic        rsp_fault;

    always #5 clk = ~clk;

    bbx_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_type(req_type), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .rsp_fault(rsp_fault)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_base [2];
    logic [31:0] m_lim  [2];
    logic [23:0] m_attr;
    // pending expectation
    bit          e_pend = 0;
    bit          e_valid;
    logic [31:0] e_paddr;
    logic [2:0]  e_attr;
    bit          e_fault;
    string       e_tag;
    string       e_atag;
    string       phase = "";

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, phase, got, exp);
        end
    endtask

    task automatic compare_pending();
        if (e_pend) begin
            check("R2 valid", 32'(rsp_valid), 32'(e_valid));
            if (e_valid) begin
                check({e_tag, " fault"}, 32'(rsp_fault), 32'(e_fault));
                check({e_tag, " paddr"}, rsp_paddr, e_paddr);
                check({e_atag, " attr"}, 32'(rsp_attr), 32'(e_attr));
            end
        end
    endtask

    task automatic step(input bit v, input bit usr, input logic [1:0] ty, input logic [31:0] va,
                        input bit we, input logic [2:0] sel, input logic [31:0] wd);
        int s;
        int r;
        compare_pending();
        req_valid = v; req_user = usr; req_type = ty; req_vaddr = va;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        s = (ty == 2'd0) ? 0 : 1;
        r = int'(va[31:29]);
        e_valid = v; e_fault = 0; e_paddr = '0; e_attr = '0;
        e_atag = "R9";
        if (va[31] && usr) begin
            e_fault = 1; e_tag = "R8"; e_atag = "R8";
        end else if (!va[31]) begin
            e_tag = (ty == 2'd3) ? "R11" : "R3";
            if (va < m_lim[s]) begin
                e_paddr = va + m_base[s];
                e_attr = m_attr[r*3 +: 3];
            end else begin
                e_fault = 1; e_tag = "R4"; e_atag = "R4";
            end
        end else if (va[31:29] == 3'b100) begin
            e_tag = "R5"; e_atag = "R5";
            e_paddr = {3'b000, va[28:0]}; e_attr = m_attr[r*3 +: 3];
        end else if (va[31:29] == 3'b101) begin
            e_tag = "R6"; e_atag = "R6";
            e_paddr = {3'b000, va[28:0]}; e_attr = 3'd2;
        end else begin
            e_tag = "R7"; e_atag = "R7";
            e_paddr = va; e_attr = m_attr[r*3 +: 3];
        end
        e_pend = 1;
        if (we) begin
            case (sel)
                3'd0: m_base[0] = wd;
                3'd1: m_lim[0]  = wd;
                3'd2: m_base[1] = wd;
                3'd3: m_lim[1]  = wd;
                3'd4: m_attr    = wd[23:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
        step(0, 0, 2'd0, 32'h0, 1, sel, wd);
    endtask

    function automatic logic [31:0] pick_addr();
        int k;
        k = int'($urandom_range(0, 9));
        case (k)
            0: return m_lim[0];
            1: return m_lim[0] - 32'd1;
            2: return m_lim[1];
            3: return m_lim[1] - 32'd1;
            4: return 32'h0;
            5: return 32'h7FFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_base[0] = '0; m_base[1] = '0; m_lim[0] = '0; m_lim[1] = '0; m_attr = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all registers zero, so user access faults
        phase = "R1 after reset";
        step(1, 1, 2'd1, 32'h0000_0000, 0, 0, 0);
        step(1, 0, 2'd0, 32'h0000_1000, 0, 0, 0);
        phase = "setup";
        wr(3'd0, 32'h1000_0000);
        wr(3'd1, 32'h0001_0000);
        wr(3'd2, 32'hF000_0000);
        wr(3'd3, 32'h0000_2000);
        wr(3'd4, 32'h00FA_C688);
        // R3 fetch vs data pairs, R4 bound edge, R9 attr
        phase = "R3 R4 edges";
        step(1, 1, 2'd0, 32'h0000_FFFF, 0, 0, 0);
        step(1, 1, 2'd0, 32'h0001_0000, 0, 0, 0);
        step(1, 1, 2'd1, 32'h0000_1FFF, 0, 0, 0);
        step(1, 1, 2'd2, 32'h0000_2000, 0, 0, 0);
        step(1, 1, 2'd3, 32'h0000_0010, 0, 0, 0);
        // kernel segments
        phase = "R5 R6 R7";
        step(1, 0, 2'd1, 32'h8123_4567, 0, 0, 0);
        step(1, 0, 2'd1, 32'hA123_4567, 0, 0, 0);
        step(1, 0, 2'd0, 32'hC000_0004, 0, 0, 0);
        step(1, 0, 2'd2, 32'hFFFF_FFFC, 0, 0, 0);
        phase = "R8 user kseg";
        step(1, 1, 2'd1, 32'h8000_0000, 0, 0, 0);
        step(1, 1, 2'd0, 32'hE000_0000, 0, 0, 0);
        // R10: ignored select codes, write/request same cycle
        phase = "R10 ignored sel";
        step(1, 1, 2'd0, 32'h0000_0100, 1, 3'd5, 32'h0);
        step(1, 1, 2'd1, 32'h0000_0100, 1, 3'd7, 32'h0);
        step(1, 1, 2'd0, 32'h0000_0100, 1, 3'd6, 32'h0);
        phase = "R10 same-cycle write";
        step(1, 1, 2'd0, 32'h0000_0200, 1, 3'd1, 32'h0000_0100);
        step(1, 1, 2'd0, 32'h0000_0200, 0, 0, 0);
        step(1, 0, 2'd0, 32'h0000_0200, 1, 3'd4, 32'hFFFF_FFFF);
        step(1, 0, 2'd0, 32'hA000_0000, 0, 0, 0);
        step(0, 0, 2'd0, 32'h0000_0000, 0, 0, 0);
        // randomized traffic
        phase = "random";
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ws;
            bit w;
            w  = ($urandom_range(0, 7) == 0);
            ws = 3'($urandom_range(0, 7));
            step(($urandom_range(0, 5) != 0), $urandom_range(0, 1) == 1,
                 2'($urandom_range(0, 3)), pick_addr(), w, ws, $urandom());
        end
        step(0, 0, 2'd0, 32'h0, 0, 0, 0);
        compare_pending();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule